// File: doc/BRIEF.md
# BCD Calendar Timekeeper Core

This block keeps wall-clock time and a calendar in packed BCD. A prescaler turns pulses from a reference enable (nominally 32.768 kHz) into a 100 Hz tick. The prescaler uses a phase accumulator, so a non-integer ratio still averages out exactly. Each tick advances a carry chain: hundredths, seconds, minutes, hours, then day of week and date together, then month and year. Day of month rolls over by month length. February gets a 29th day in every year whose two-digit value is a multiple of four, which holds for every year through 2099.

A byte-wide register port reaches every field at its own address. Writes are synchronous and presetting. The read data is registered. The hour register supports both 24-hour and 12-hour formats, the latter with an AM/PM flag. The month register carries an active-low oscillator enable. While that enable is inactive, the prescaler and every counter freeze. Any write to a mapped register restarts the prescaler phase, so the value written stays in place for one full tick period.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: Address 0x0 holds hundredths as two BCD digits (tenths in bits 7:4), counting 00..99 on each tick; 99 wraps to 00 and advances seconds.
- R2: Addresses 0x1 (seconds) and 0x2 (minutes) count 00..59 in BCD and wrap with a carry to the next field; bit 7 is discarded on write and reads 0.
- R3: Address 0x4 with bit 6 clear is a 24-hour BCD hour in bits 5:0, counting 00..23; 23 wraps to 00 and advances day of week and date; bit 7 reads 0.
- R4: Address 0x4 with bit 6 set is a 12-hour hour (01..12 in bits 4:0, bit 5 = 1 for PM). 11 goes to 12 with bit 5 inverted, 12 goes to 01 with bit 5 unchanged, and only the 11 PM to 12 AM step advances the day.
- R5: Address 0x6 holds day of week in bits 2:0, counting 01..07 and wrapping to 01; bits 7:3 read 0.
- R6: Address 0x8 holds the date in bits 5:0. It wraps to 01 after 31 for months 01, 03, 05, 07, 08, 10, 12 and after 30 for 04, 06, 09, 11, carrying into the month. Bit 6 reads 0.
- R7: For month 02 the date wraps after 29 when the BCD year at 0xA is a multiple of four (00 included), otherwise after 28.
- R8: Address 0x9 holds the month in bits 4:0, 12 wrapping to 01 with a carry into address 0xA, a BCD year 00..99 that wraps 99 to 00; bit 5 of 0x9 reads 0.
- R9: Bit 7 of 0x8 and bits 7:6 of 0x9 are read/write control bits that counting never alters. Addresses 0x3, 0x5, 0x7 and 0xB..0xF read 00 and ignore writes.
- R10: While bit 7 of 0x9 is 1 (oscillator disabled) no tick occurs, the prescaler phase holds and all time fields hold.
- R11: Every reference pulse adds TICK_HZ to a phase that emits a tick and subtracts REF_HZ when it would reach REF_HZ. A write to a mapped address clears the phase and suppresses the tick in that cycle.
- R12: Read data appears on the clock edge after the address is presented and shows the register contents before any update made on that same edge.
- R13: Synchronous active-high reset gives 00.00 s, 00 min, hour 00 in 24-hour mode, day 01, date 01, month 01, year 00, all control bits 0 and read data 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | One-cycle enable per reference period |
| bus_wr | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_addr | input | 4 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The bench builds the block with REF_HZ = 5 and TICK_HZ = 2. A tick therefore follows every two or three reference pulses, in an uneven pattern that exercises the fractional phase rule. Because ticks come every few cycles, presets written just before each rollover reach full-day, month-end, February and year-end boundaries within a few dozen cycles. The bench also randomises the reference pulses and sweeps the read address over all sixteen locations. This places writes, stalled oscillators and reads of unmapped addresses at every phase of the accumulator.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  typedef logic [DATA_W-1:0] byte_t;

  localparam logic [ADDR_W-1:0] A_HUND = 4'h0;
  localparam logic [ADDR_W-1:0] A_SEC  = 4'h1;
  localparam logic [ADDR_W-1:0] A_MIN  = 4'h2;
  localparam logic [ADDR_W-1:0] A_HOUR = 4'h4;
  localparam logic [ADDR_W-1:0] A_DOW  = 4'h6;
  localparam logic [ADDR_W-1:0] A_DATE = 4'h8;
  localparam logic [ADDR_W-1:0] A_MON  = 4'h9;
  localparam logic [ADDR_W-1:0] A_YEAR = 4'hA;

  function automatic byte_t bcd_inc(byte_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // two-digit BCD year divisible by four
  function automatic logic yr_leap(byte_t y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic byte_t month_last(byte_t m, logic leap);
    case (m)
      8'h02: return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic logic addr_mapped(logic [ADDR_W-1:0] a);
    return (a == A_HUND) || (a == A_SEC) || (a == A_MIN) || (a == A_HOUR) ||
           (a == A_DOW) || (a == A_DATE) || (a == A_MON) || (a == A_YEAR);
  endfunction
endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int REF_HZ  = 32768,
  parameter int TICK_HZ = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_pulse,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int ACC_W = $clog2(REF_HZ + TICK_HZ + 1);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;

  assign sum  = acc + ACC_W'(TICK_HZ);
  assign tick = ref_pulse && run && !clr && (sum >= ACC_W'(REF_HZ));

  always_ff @(posedge clk) begin
    if (rst || clr)           acc <= '0;
    else if (ref_pulse && run) acc <= tick ? sum - ACC_W'(REF_HZ) : sum;
  end

  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> acc == '0); // R11
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
    acc < ACC_W'(REF_HZ)); // R11
  AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(acc)); // R10
endmodule

// File: rtl/rtc_chain.sv
module rtc_chain
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr,
  input  logic [ADDR_W-1:0] waddr,
  input  byte_t             wdata,
  output byte_t             hund,
  output byte_t             sec,
  output byte_t             mins,
  output byte_t             hour,
  output byte_t             dow,
  output byte_t             date,
  output byte_t             mon,
  output byte_t             year
);
  logic  c_hund, c_sec, c_min, c_hr, c_date, c_mon;
  byte_t h12_inc, h24_inc, hour_nx, date_inc, mon_inc, dlast;

  always_comb begin
    c_hund = tick && (hund == 8'h99);
    c_sec  = c_hund && (sec == 8'h59);
    c_min  = c_sec && (mins == 8'h59);
    h12_inc = bcd_inc({3'b0, hour[4:0]});
    h24_inc = bcd_inc({2'b0, hour[5:0]});
    if (hour[6]) begin
      c_hr = c_min && hour[5] && (hour[4:0] == 5'h11);
      if (hour[4:0] == 5'h11)      hour_nx = {hour[7:6], ~hour[5], 5'h12};
      else if (hour[4:0] == 5'h12) hour_nx = {hour[7:5], 5'h01};
      else                         hour_nx = (h12_inc & 8'h1F) | {hour[7:5], 5'b0};
    end else begin
      c_hr = c_min && (hour[5:0] == 6'h23);
      if (hour[5:0] == 6'h23) hour_nx = {hour[7:6], 6'h00};
      else                    hour_nx = (h24_inc & 8'h3F) | {hour[7:6], 6'b0};
    end
    dlast    = month_last({3'b0, mon[4:0]}, yr_leap(year));
    date_inc = bcd_inc({2'b0, date[5:0]});
    mon_inc  = bcd_inc({3'b0, mon[4:0]});
    c_date   = c_hr && ({2'b0, date[5:0]} == dlast);
    c_mon    = c_date && (mon[4:0] == 5'h12);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hund <= 8'h00; sec <= 8'h00; mins <= 8'h00; hour <= 8'h00;
      dow  <= 8'h01; date <= 8'h01; mon <= 8'h01; year <= 8'h00;
    end else if (wr) begin
      case (waddr)
        A_HUND: hund <= wdata;
        A_SEC:  sec  <= wdata & 8'h7F;
        A_MIN:  mins <= wdata & 8'h7F;
        A_HOUR: hour <= wdata & 8'h7F;
        A_DOW:  dow  <= wdata & 8'h07;
        A_DATE: date <= wdata & 8'hBF;
        A_MON:  mon  <= wdata & 8'hDF;
        A_YEAR: year <= wdata;
        default: ;
      endcase
    end else begin
      if (tick)   hund <= c_hund ? 8'h00 : bcd_inc(hund);
      if (c_hund) sec  <= c_sec ? 8'h00 : bcd_inc(sec);
      if (c_sec)  mins <= c_min ? 8'h00 : bcd_inc(mins);
      if (c_min)  hour <= hour_nx;
      if (c_hr) begin
        dow  <= (dow == 8'h07) ? 8'h01 : bcd_inc(dow);
        date <= c_date ? {date[7], 7'h01} : ((date_inc & 8'h3F) | {date[7], 7'b0});
      end
      if (c_date) mon  <= c_mon ? {mon[7:5], 5'h01} : ((mon_inc & 8'h1F) | {mon[7:5], 5'b0});
      if (c_mon)  year <= (year == 8'h99) ? 8'h00 : bcd_inc(year);
    end
  end

  AST_HUND_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr && hund == 8'h99) |=> hund == 8'h00); // R1
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (c_sec && !wr) |=> sec == 8'h00); // R2
  AST_AMPM_FLIP: assert property (@(posedge clk) disable iff (rst)
    (c_min && !wr && hour[6] && hour[4:0] == 5'h11) |=> hour[5] != $past(hour[5])); // R4
  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (rst)
    (c_hr && !wr && dow == 8'h07) |=> dow == 8'h01); // R5
  AST_DATE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (c_date && !wr) |=> date[5:0] == 6'h01); // R6
  AST_CTL_KEEP: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(date[7]) && $stable(mon[7:6]))); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr) |=> $stable({hund, sec, mins, hour, dow, date, mon, year})); // R10
endmodule

// File: rtl/rtc_readmux.sv
module rtc_readmux
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] raddr,
  input  byte_t             hund,
  input  byte_t             sec,
  input  byte_t             mins,
  input  byte_t             hour,
  input  byte_t             dow,
  input  byte_t             date,
  input  byte_t             mon,
  input  byte_t             year,
  output byte_t             rdata
);
  byte_t sel;

  always_comb begin
    case (raddr)
      A_HUND:  sel = hund;
      A_SEC:   sel = sec;
      A_MIN:   sel = mins;
      A_HOUR:  sel = hour;
      A_DOW:   sel = dow;
      A_DATE:  sel = date;
      A_MON:   sel = mon;
      A_YEAR:  sel = year;
      default: sel = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else     rdata <= sel;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !addr_mapped(raddr) |=> rdata == 8'h00); // R9
endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
  import rtc_pkg::*;
#(
  parameter int REF_HZ  = 32768,
  parameter int TICK_HZ = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_pulse,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic  wr_hit, tick, osc_run;
  byte_t hund, sec, mins, hour, dow, date, mon, year;

  assign wr_hit  = bus_wr && addr_mapped(bus_addr);
  assign osc_run = !mon[7];

  rtc_prescale #(.REF_HZ(REF_HZ), .TICK_HZ(TICK_HZ)) u_pre (
    .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .run(osc_run),
    .clr(wr_hit), .tick(tick)
  );

  rtc_chain u_chain (
    .clk(clk), .rst(rst), .tick(tick), .wr(wr_hit), .waddr(bus_addr),
    .wdata(bus_wdata), .hund(hund), .sec(sec), .mins(mins), .hour(hour),
    .dow(dow), .date(date), .mon(mon), .year(year)
  );

  rtc_readmux u_rd (
    .clk(clk), .rst(rst), .raddr(bus_addr), .hund(hund), .sec(sec),
    .mins(mins), .hour(hour), .dow(dow), .date(date), .mon(mon),
    .year(year), .rdata(bus_rdata)
  );

  AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !osc_run |-> !tick); // R10
endmodule

// File: tb/bcd_calendar_rtc_test.sv
module bcd_calendar_rtc_test;
  localparam int CLK_PERIOD = 10;
  localparam int REF = 5;
  localparam int TCK = 2;
  localparam int WATCHDOG = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_pulse = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  bcd_calendar_rtc #(.REF_HZ(REF), .TICK_HZ(TCK)) uut (
    .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model: plain integers
  int m_acc, m_h, m_s, m_m, m_hr, m_dow, m_dt, m_mo, m_yr;
  bit m_12, m_pm, m_dctl, m_osc_off, m_sqw;
  logic [7:0] exp_rdata = 8'h00;
  bit   started = 0;
  int   compared = 0, mismatched = 0, cycles = 0;
  string phase = "R13";

  function automatic int b2i(logic [7:0] v); return v[7:4] * 10 + v[3:0]; endfunction
  function automatic logic [7:0] i2b(int v); return {4'(v / 10), 4'(v % 10)}; endfunction

  function automatic int mlen(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28; // R7
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] m_read(logic [3:0] a);
    case (a)
      4'h0: return i2b(m_h);
      4'h1: return i2b(m_s);
      4'h2: return i2b(m_m);
      4'h4: return m_12 ? {1'b0, 1'b1, m_pm, i2b(m_hr)[4:0]} : i2b(m_hr);
      4'h6: return 8'(m_dow);
      4'h8: return {m_dctl, 1'b0, i2b(m_dt)[5:0]};
      4'h9: return {m_osc_off, m_sqw, 1'b0, i2b(m_mo)[4:0]};
      4'hA: return i2b(m_yr);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(logic [3:0] a);
    case (a)
      4'h0: return "R1";
      4'h1, 4'h2: return "R2";
      4'h4: return "R3/R4";
      4'h6: return "R5";
      4'h8: return "R6";
      4'h9, 4'hA: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic m_advance();
    bit c;
    m_h++; if (m_h < 100) return; m_h = 0;
    m_s++; if (m_s < 60) return; m_s = 0;
    m_m++; if (m_m < 60) return; m_m = 0;
    c = 0;
    if (m_12) begin
      if (m_hr == 11) begin m_hr = 12; m_pm = !m_pm; c = !m_pm; end
      else if (m_hr == 12) m_hr = 1;
      else m_hr++;
    end else begin
      m_hr++; if (m_hr == 24) begin m_hr = 0; c = 1; end
    end
    if (!c) return;
    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
    if (m_dt < mlen(m_mo, m_yr)) begin m_dt++; return; end
    m_dt = 1;
    if (m_mo < 12) begin m_mo++; return; end
    m_mo = 1;
    m_yr = (m_yr + 1) % 100;
  endtask

  task automatic m_write(logic [3:0] a, logic [7:0] d);
    case (a)
      4'h0: m_h = b2i(d);
      4'h1: m_s = b2i(d & 8'h7F);
      4'h2: m_m = b2i(d & 8'h7F);
      4'h4: begin
        m_12 = d[6];
        m_pm = d[6] ? d[5] : 1'b0;
        m_hr = d[6] ? b2i(d & 8'h1F) : b2i(d & 8'h3F);
      end
      4'h6: m_dow = int'(d & 8'h07);
      4'h8: begin m_dctl = d[7]; m_dt = b2i(d & 8'h3F); end
      4'h9: begin m_osc_off = d[7]; m_sqw = d[6]; m_mo = b2i(d & 8'h1F); end
      4'hA: m_yr = b2i(d);
      default: ;
    endcase
  endtask

  function automatic bit mapped(logic [3:0] a);
    return a == 0 || a == 1 || a == 2 || a == 4 || a == 6 || a == 8 || a == 9 || a == 10;
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_acc = 0; m_h = 0; m_s = 0; m_m = 0; m_hr = 0; m_12 = 0; m_pm = 0;
      m_dow = 1; m_dt = 1; m_mo = 1; m_yr = 0; m_dctl = 0; m_osc_off = 0; m_sqw = 0;
      exp_rdata = 8'h00;
    end else begin
      exp_rdata = m_read(bus_addr); // R12: pre-update contents
      if (bus_wr && mapped(bus_addr)) begin
        m_acc = 0; // R11
        m_write(bus_addr, bus_wdata);
      end else if (ref_pulse && !m_osc_off) begin // R10
        m_acc += TCK;
        if (m_acc >= REF) begin m_acc -= REF; m_advance(); end
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      compared++;
      if (bus_rdata !== exp_rdata) begin
        mismatched++;
        $display("FAIL %s [%s] addr %h: actual %h expected %h",
                 req_of(bus_addr), phase, bus_addr, bus_rdata, exp_rdata);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic run(int n, bit rnd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_addr = 4'(i);
      ref_pulse = rnd ? (($urandom % 4) != 0) : 1'b1;
    end
  endtask

  task automatic set_time(logic [7:0] hr, logic [7:0] mi, logic [7:0] se, logic [7:0] hu);
    wr(4'h4, hr); wr(4'h2, mi); wr(4'h1, se); wr(4'h0, hu);
  endtask

  task automatic set_date(logic [7:0] yr, logic [7:0] mo, logic [7:0] dt, logic [7:0] dw);
    wr(4'hA, yr); wr(4'h9, mo); wr(4'h8, dt); wr(4'h6, dw);
  endtask

  initial begin
    // R13: reset values read out over all addresses
    repeat (3) @(negedge clk);
    rst = 0;
    ref_pulse = 0;
    run(32, 0);
    // R1, R11: free run, steady and random reference pulses
    phase = "R1"; run(400, 0); run(400, 1);
    // R2: bit 7 discarded on seconds and minutes
    phase = "R2"; set_time(8'h00, 8'hD9, 8'hB9, 8'h90); run(200, 1);
    // R3, R8: full rollover at year end in 24-hour mode
    phase = "R3"; set_date(8'h99, 8'h12, 8'h31, 8'h07); set_time(8'h23, 8'h59, 8'h59, 8'h95); run(60, 0);
    // R7: February in non-leap, leap and year 00
    phase = "R7"; set_date(8'h23, 8'h02, 8'h28, 8'h03); set_time(8'h23, 8'h59, 8'h59, 8'h97); run(40, 0);
    set_date(8'h24, 8'h02, 8'h28, 8'h03); set_time(8'h23, 8'h59, 8'h59, 8'h97); run(40, 0);
    set_time(8'h23, 8'h59, 8'h59, 8'h97); run(40, 0);
    set_date(8'h00, 8'h02, 8'h29, 8'h05); set_time(8'h23, 8'h59, 8'h59, 8'h97); run(40, 1);
    set_date(8'h18, 8'h02, 8'h28, 8'h05); set_time(8'h23, 8'h59, 8'h59, 8'h97); run(40, 1);
    // R6: 30-day and 31-day months, control bit in date kept
    phase = "R6"; set_date(8'h31, 8'h04, 8'hB0, 8'h02); set_time(8'h23, 8'h59, 8'h59, 8'h97); run(40, 0);
    set_date(8'h31, 8'h07, 8'h31, 8'h02); set_time(8'h23, 8'h59, 8'h59, 8'h97); run(40, 0);
    set_date(8'h31, 8'h11, 8'h30, 8'h02); set_time(8'h23, 8'h59, 8'h59, 8'h97); run(40, 0);
    // R4: 12-hour transitions, 11 PM -> 12 AM advances the day
    phase = "R4"; set_date(8'h45, 8'h06, 8'h30, 8'h07); set_time(8'h71, 8'h59, 8'h59, 8'h97); run(40, 0);
    set_time(8'h51, 8'h59, 8'h59, 8'h97); run(40, 0);
    set_time(8'h52, 8'h59, 8'h59, 8'h97); run(40, 0);
    set_time(8'h72, 8'h59, 8'h59, 8'h97); run(40, 0);
    set_time(8'h49, 8'h59, 8'h59, 8'h97); run(40, 0);
    // R5: day of week wrap in 24-hour mode
    phase = "R5"; set_date(8'h10, 8'h03, 8'h10, 8'h07); set_time(8'h23, 8'h59, 8'h59, 8'h97); run(40, 1);
    // R10: oscillator disabled freezes everything, then resumes
    phase = "R10"; set_time(8'h10, 8'h59, 8'h59, 8'h90); wr(4'h9, 8'h83); run(200, 0);
    wr(4'h9, 8'h43); run(200, 1);
    // R9: unmapped writes ignored and do not clear the phase
    phase = "R9";
    for (int a = 0; a < 16; a++) if (!mapped(4'(a))) wr(4'(a), 8'hA5);
    run(64, 1);
    // R11: back-to-back writes keep the written value
    phase = "R11";
    for (int k = 0; k < 20; k++) begin wr(4'h0, 8'h42); ref_pulse = 1; end
    run(64, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule